// File: doc/BRIEF.md
# Secured Configuration Store Controller

This block sits between a device programming port and a small array of configuration words. The programming side issues one command at a time over a valid/ready command channel and collects one result per command over a valid/ready response channel. The commands write a word, read a word back for verification, engage the security lock, wipe the whole array, read a fixed identification signature, or write a word and engage the lock in one step.

The security lock blocks all read-back and all further writing. Once it is set, the only way to clear it is a full wipe, which also returns every word to the erased value. The signature stays readable while the lock is set, so a locked part can still be identified. A wipe takes a fixed number of cycles, and the block reports busy for that whole time.

Back-pressure rules: `cmd_ready` is high only while the block is idle. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. A command presented while `cmd_ready` is low has no effect and is not queued. Once a response is raised, it holds its value until `rsp_ready` is seen high on a rising edge. No new command is taken before that edge.

Top module: `cfg_secure_store`

## Requirements
- R1: After reset, `cmd_ready` is 1, `busy` is 0, `rsp_valid` is 0 and `secured` is 0, and every word reads back as all ones.
- R2: Opcode 0 (write) on an unlocked store puts `cmd_data` at `cmd_addr` and returns status 0 (ok). Opcode 1 (read) on an unlocked store returns that word with status 0.
- R3: Opcode 1 (read) while `secured` is 1 returns data 0 with status 1 (denied).
- R4: Opcode 0 (write) while `secured` is 1 returns status 1 with data 0 and leaves the array untouched.
- R5: Opcode 2 (lock) always returns status 0 and sets `secured`, including when it is already set.
- R6: Opcode 5 (write then lock) on an unlocked store writes the word, sets `secured` and returns status 0. On a locked store it returns status 1 and changes nothing.
- R7: Opcode 3 (wipe) returns status 0 with data 0. The response appears `ERASE_CYCLES`+1 cycles after the accepting edge. After the wipe, every word reads all ones and `secured` is 0.
- R8: Opcode 4 (signature) returns `SIGNATURE` with status 0, whether or not the store is locked.
- R9: A command presented while `cmd_ready` is 0 is ignored, and `busy` is always the inverse of `cmd_ready`.
- R10: For opcodes other than 3, the response is valid in the cycle after the accepting edge. The response holds stable until it is taken, and `cmd_ready` returns to 1 in the cycle after it is taken.
- R11: Opcodes 6 and 7 return status 1 with data 0 and change neither the array nor the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command will be taken |
| cmd_op | input | 3 | Opcode (0 write, 1 read, 2 lock, 3 wipe, 4 signature, 5 write then lock) |
| cmd_addr | input | ADDR_W | Word address |
| cmd_data | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken on a rising edge where it is high |
| rsp_status | output | 1 | 0 ok, 1 denied |
| rsp_data | output | DATA_W | Read or signature data, 0 otherwise |
| busy | output | 1 | A command is in progress or its response is waiting |
| secured | output | 1 | Security lock state |

## Verification
The main function is exercised three ways. Directed write/read pairs at the lowest and highest addresses separate the addressing from the data path. A fixed lock sequence (lock, blocked read, blocked write, signature, second lock, blocked write-then-lock, wipe) separates the lock gating from ordinary access. A seeded random mix of all eight opcodes, with random response stalls, exposes ordering faults between locking, wiping and writing that no directed case reaches. One case presents a write while a response is stalled and then reads the same word back, which tells an ignored command apart from a queued or applied one.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  typedef enum logic [2:0] {
    OP_WRITE      = 3'd0,
    OP_READ       = 3'd1,
    OP_LOCK       = 3'd2,
    OP_WIPE       = 3'd3,
    OP_SIGNATURE  = 3'd4,
    OP_WRITE_LOCK = 3'd5
  } cfgs_op_e;

  localparam logic ST_OK     = 1'b0;
  localparam logic ST_DENIED = 1'b1;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WIPE = 2'd1,
    S_RESP = 2'd2
  } cfgs_state_e;
endpackage

// File: rtl/cfgs_array.sv
module cfgs_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wipe_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] word_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q[gi] <= '1;
      else if (wipe_en)
        word_q[gi] <= '1;
      else if (wr_en && wr_addr == ADDR_W'(gi))
        word_q[gi] <= wr_data;
    end
  end

  assign rd_data = word_q[rd_addr];

  AST_WIPE_ONES: assert property (@(posedge clk) disable iff (!rst_n) wipe_en |=> (word_q[0] == '1) && (word_q[DEPTH-1] == '1)) else $error("wipe left data"); // R7
endmodule

// File: rtl/cfgs_wipe_timer.sv
module cfgs_wipe_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= CNT_W'(CYCLES - 1);
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = run_q && (cnt_q == '0);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done) else $error("timer done repeated"); // R7
endmodule

// File: rtl/cfgs_ctrl.sv
module cfgs_ctrl
  import cfgs_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] SIGNATURE = 'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_status,
  output logic [DATA_W-1:0] rsp_data,
  output logic              secured,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wipe_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              tmr_start,
  input  logic              tmr_done
);
  cfgs_state_e       state_q;
  logic              lock_q;
  logic              stat_q;
  logic [DATA_W-1:0] data_q;

  logic              accept;
  cfgs_op_e          op;
  logic              acc_stat;
  logic [DATA_W-1:0] acc_data;
  logic              acc_lock;

  assign op        = cfgs_op_e'(cmd_op);
  assign cmd_ready = (state_q == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign rd_addr   = cmd_addr;
  assign wr_addr   = cmd_addr;
  assign wr_data   = cmd_data;
  assign tmr_start = accept && (op == OP_WIPE);
  assign wipe_en   = (state_q == S_WIPE) && tmr_done;

  // Result of a non-wipe command, decided at the accepting edge
  always_comb begin
    acc_stat = ST_OK;
    acc_data = '0;
    acc_lock = lock_q;
    wr_en    = 1'b0;
    unique case (op)
      OP_WRITE: begin
        if (lock_q) acc_stat = ST_DENIED;
        else        wr_en    = accept;
      end
      OP_READ: begin
        if (lock_q) acc_stat = ST_DENIED;
        else        acc_data = rd_data;
      end
      OP_LOCK:      acc_lock = 1'b1;
      OP_SIGNATURE: acc_data = SIGNATURE;
      OP_WRITE_LOCK: begin
        if (lock_q) acc_stat = ST_DENIED;
        else begin
          wr_en    = accept;
          acc_lock = 1'b1;
        end
      end
      OP_WIPE:      acc_stat = ST_OK;
      default:      acc_stat = ST_DENIED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      lock_q  <= 1'b0;
      stat_q  <= ST_OK;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          if (op == OP_WIPE) begin
            state_q <= S_WIPE;
          end else begin
            state_q <= S_RESP;
            stat_q  <= acc_stat;
            data_q  <= acc_data;
            lock_q  <= acc_lock;
          end
        end
        S_WIPE: if (tmr_done) begin
          state_q <= S_RESP;
          lock_q  <= 1'b0;
          stat_q  <= ST_OK;
          data_q  <= '0;
        end
        S_RESP: if (rsp_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rsp_valid  = (state_q == S_RESP);
  assign rsp_status = stat_q;
  assign rsp_data   = data_q;
  assign secured    = lock_q;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_status)) else $error("response changed"); // R10
  AST_DENIED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid && rsp_status == ST_DENIED |-> rsp_data == '0) else $error("denied with data"); // R3
  AST_UNLOCK_BY_WIPE: assert property (@(posedge clk) disable iff (!rst_n) $fell(lock_q) |-> $past(wipe_en)) else $error("lock cleared without wipe"); // R7
  AST_IDLE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid && rsp_ready |=> cmd_ready) else $error("not idle after take"); // R10
endmodule

// File: rtl/cfg_secure_store.sv
module cfg_secure_store #(
  parameter int                ADDR_W       = 4,
  parameter int                DATA_W       = 8,
  parameter int                ERASE_CYCLES = 8,
  parameter logic [DATA_W-1:0] SIGNATURE    = 'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_status,
  output logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              secured
);
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              wipe_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              tmr_start;
  logic              tmr_done;

  cfgs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIGNATURE(SIGNATURE)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_status(rsp_status), .rsp_data(rsp_data), .secured(secured),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wipe_en(wipe_en),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .tmr_start(tmr_start), .tmr_done(tmr_done)
  );

  cfgs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wipe_en(wipe_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  cfgs_wipe_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .done(tmr_done)
  );

  assign busy = !cmd_ready;

  AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) secured |-> !wr_en) else $error("write while secured"); // R4
  AST_WIPE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) wipe_en |-> busy && !rsp_valid) else $error("wipe outside busy"); // R7
endmodule

// File: tb/cfg_secure_store_tb.sv
module cfg_secure_store_tb;
  localparam int          AW  = 4;
  localparam int          DW  = 8;
  localparam int          EC  = 8;
  localparam logic [7:0]  SIG = 8'hA5;
  localparam int          DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cmd_valid = 1'b0, cmd_ready, rsp_valid, rsp_ready = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0, rsp_data;
  logic          rsp_status, busy, secured;

  cfg_secure_store #(.ADDR_W(AW), .DATA_W(DW), .ERASE_CYCLES(EC), .SIGNATURE(SIG)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_data(rsp_data), .busy(busy), .secured(secured)
  );

  logic [DW-1:0] mdl_mem [DEPTH];
  logic          mdl_lock;
  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2/R4 write";
      3'd1: return "R2/R3 read";
      3'd2: return "R5 lock";
      3'd3: return "R7 wipe";
      3'd4: return "R8 signature";
      3'd5: return "R6 write-lock";
      default: return "R11 illegal";
    endcase
  endfunction

  task automatic model(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output logic st, output logic [DW-1:0] q, output int lat);
    lat = 1; st = 1'b0; q = '0;
    case (op)
      3'd0: if (mdl_lock) st = 1'b1; else mdl_mem[a] = d;
      3'd1: if (mdl_lock) st = 1'b1; else q = mdl_mem[a];
      3'd2: mdl_lock = 1'b1;
      3'd3: begin
        lat = EC + 1;
        for (int i = 0; i < DEPTH; i++) mdl_mem[i] = '1;
        mdl_lock = 1'b0;
      end
      3'd4: q = SIG;
      3'd5: if (mdl_lock) st = 1'b1; else begin mdl_mem[a] = d; mdl_lock = 1'b1; end
      default: st = 1'b1;
    endcase
  endtask

  task automatic run(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input int hold, input bit poke);
    logic          est;
    logic [DW-1:0] eq;
    int            elat;
    int            lat;
    string         tag;
    tag = tag_of(op);
    model(op, a, d, est, eq, elat);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 100) begin @(negedge clk); lat++; end
    chk(lat == elat, {tag, " R10 latency"}, lat, elat);
    chk(rsp_status == est, {tag, " status"}, rsp_status, est);
    chk(rsp_data == eq, {tag, " data"}, rsp_data, eq);
    for (int k = 0; k < hold; k++) begin
      if (poke && k == 0) begin
        cmd_op = 3'd0; cmd_addr = a; cmd_data = ~d; cmd_valid = 1'b1;
      end
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(rsp_valid && rsp_data == eq && rsp_status == est, {tag, " R10 hold"}, rsp_data, eq);
      chk(!cmd_ready && busy, "R9 busy while response waits", cmd_ready, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(cmd_ready && !busy && !rsp_valid, "R10/R9 idle after take", {busy, rsp_valid}, 0);
    chk(secured == mdl_lock, {tag, " R5 secured flag"}, secured, mdl_lock);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [2:0]    op;
    int            r;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) mdl_mem[i] = '1;
    mdl_lock = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !busy && !rsp_valid && !secured, "R1 reset outputs", {cmd_ready, busy, rsp_valid, secured}, 4'b1000);
    run(3'd1, 4'd3, 8'h00, 0, 0);               // R1 erased contents
    run(3'd1, 4'd15, 8'h00, 1, 0);              // R1
    run(3'd0, 4'd3, 8'h5A, 0, 0);               // R2
    run(3'd1, 4'd3, 8'h00, 2, 0);               // R2
    run(3'd0, 4'd0, 8'h00, 0, 0);               // R2 low address
    run(3'd0, 4'd15, 8'hC3, 0, 0);              // R2 high address
    run(3'd1, 4'd0, 8'h00, 0, 0);
    run(3'd1, 4'd15, 8'h00, 0, 0);
    run(3'd1, 4'd3, 8'h11, 3, 1);               // R9 write poked while busy
    run(3'd1, 4'd3, 8'h00, 0, 0);               // R9 poke had no effect
    run(3'd4, 4'd0, 8'h00, 0, 0);               // R8
    run(3'd6, 4'd3, 8'h77, 0, 0);               // R11
    run(3'd7, 4'd3, 8'h77, 1, 0);               // R11
    run(3'd1, 4'd3, 8'h00, 0, 0);               // R11 no effect
    run(3'd2, 4'd0, 8'h00, 0, 0);               // R5
    run(3'd1, 4'd3, 8'h00, 0, 0);               // R3
    run(3'd0, 4'd3, 8'h99, 0, 0);               // R4
    run(3'd4, 4'd0, 8'h00, 0, 0);               // R8 while secured
    run(3'd2, 4'd0, 8'h00, 0, 0);               // R5 repeated lock
    run(3'd5, 4'd4, 8'h42, 0, 0);               // R6 denied when secured
    run(3'd3, 4'd0, 8'h00, 2, 0);               // R7
    run(3'd1, 4'd3, 8'h00, 0, 0);               // R7 all ones, R4 blocked write absent
    run(3'd1, 4'd15, 8'h00, 0, 0);              // R7
    run(3'd5, 4'd7, 8'h3C, 0, 0);               // R6
    run(3'd1, 4'd7, 8'h00, 0, 0);               // R6 then R3
    run(3'd3, 4'd0, 8'h00, 0, 0);               // R7
    run(3'd1, 4'd7, 8'h00, 0, 0);               // R7 write-lock word wiped
    for (int n = 0; n < 400; n++) begin
      r = $urandom_range(0, 99);
      if      (r < 30) op = 3'd0;
      else if (r < 60) op = 3'd1;
      else if (r < 66) op = 3'd2;
      else if (r < 71) op = 3'd3;
      else if (r < 81) op = 3'd4;
      else if (r < 88) op = 3'd5;
      else             op = 3'($urandom_range(6, 7));
      run(op, AW'($urandom_range(0, DEPTH - 1)), DW'($urandom), $urandom_range(0, 3), ($urandom_range(0, 9) == 0));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule